// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a four-wire serial slave that lets an external master read and write a bank of internal registers. The register widths range from one to five bytes. The serial clock, chip select and data input arrive from pins. They are brought into the system clock domain by two-flop synchronisers and handled as sampled levels, so the serial clock must be much slower than the system clock.

Each frame opens with a command byte, which carries the transfer direction and a register address. One or more data bytes follow. The number of data bytes comes from a per-address length table. Writes reach the register file as a single commit pulse once the final bit has arrived. Reads raise a strobe for the addressed register as soon as the command byte is complete, so that registers which clear on read can react. The read data returned by the register file is captured in that same cycle and shifted out. The data output comes with an enable that a pad cell uses to tri-state the pin.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, and whenever chip select is high, `miso_oe`, `reg_wr` and `reg_rd` are low.
- R2: The first eight bits of a frame form the command byte. Bit 7 set means write and bit 7 clear means read. Bits 4..0 are the register address. Bits 6..5 are ignored. `reg_addr` holds the address from the end of the command byte until the next command byte completes.
- R3: The number of data bytes for an address `a` is the 4-bit field `LEN_TABLE[4a+3:4a]`. The default table gives `(a mod 5) + 1` bytes.
- R4: Data bits are taken on the falling edge of `sclk`. Bytes travel most significant first, and within a byte the MSB goes first. Write data shows up right-aligned on `reg_wdata`, with any unused upper bits set to zero.
- R5: A write frame yields exactly one `reg_wr` pulse of one cycle, after the last bit of the last data byte, and none before.
- R6: A read frame yields exactly one `reg_rd` pulse of one cycle after the command byte, and `reg_addr` is valid during that pulse. The low `8*n` bits of `reg_rdata` are captured in that cycle. They are then driven on `miso` MSB first, with each new bit appearing after a rising edge of `sclk`.
- R7: `miso_oe` goes high at the first rising edge of `sclk` after the command byte of a read. It goes low after the falling edge that ends the last data bit, or when chip select rises. It is never high during a write frame.
- R8: Raising chip select aborts the frame. An incomplete write is never committed, and the next frame starts with a fresh command byte.
- R9: `sclk` edges after the last data byte of a frame have no effect: there is no further commit, strobe or output drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the `miso` pad |
| reg_addr | output | AW | Addressed register |
| reg_wr | output | 1 | One-cycle write commit |
| reg_wdata | output | DW | Right-aligned write data |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | DW | Read data for `reg_addr`, sampled during `reg_rd` |

## Verification
The assertions assume that every serial clock phase lasts several system clock cycles, so that each rising and falling edge is seen once after synchronisation. They also assume that `mosi` is stable around each falling edge and that `reg_rdata` is valid in the cycle `reg_rd` is high. The bench keeps within these limits: it holds each `sclk` phase for eight system clocks, changes `mosi` only at the start of the high phase, and returns `reg_rdata` combinationally from its own register model. It also keeps chip select idle for several cycles between frames.

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int AW = 5,
  parameter int DW = 40,
  parameter logic [4*(1<<AW)-1:0] LEN_TABLE = 128'h21_54321_54321_54321_54321_54321_54321
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  output logic          reg_rd
);
  localparam int MAXB = DW / 8;

  typedef enum logic [1:0] {ST_CMD, ST_DATA, ST_DONE} st_t;

  logic [2:0] sclk_q;
  logic [1:0] cs_q, mosi_q;
  st_t        st;
  logic [7:0] cmd;
  logic [7:0] nbit;
  logic [3:0] nby;
  logic       wr_dir;
  logic [DW-1:0] wsr, osr;

  wire sfall  = sclk_q[2] & ~sclk_q[1];
  wire srise  = ~sclk_q[2] & sclk_q[1];
  wire cs_off = cs_q[1];
  wire din    = mosi_q[1];
  wire [7:0] cmd_n = {cmd[6:0], din};
  wire last_bit = (int'(nbit) + 1) == 8 * int'(nby);

  assign reg_wdata = wsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_CMD;
      cmd <= '0;
      nbit <= '0;
      nby <= '0;
      wr_dir <= 1'b0;
      wsr <= '0;
      osr <= '0;
      miso <= 1'b0;
      miso_oe <= 1'b0;
      reg_addr <= '0;
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (cs_off) begin
        st <= ST_CMD;
        nbit <= '0;
        miso_oe <= 1'b0;
      end else begin
        if (reg_rd) osr <= reg_rdata << (8 * (MAXB - int'(nby)));
        case (st)
          ST_CMD: if (sfall) begin
            cmd <= cmd_n;
            if (nbit == 8'd7) begin
              nbit <= '0;
              reg_addr <= cmd_n[AW-1:0];
              wr_dir <= cmd_n[7];
              nby <= LEN_TABLE[4*cmd_n[AW-1:0] +: 4];
              wsr <= '0;
              reg_rd <= ~cmd_n[7];
              st <= ST_DATA;
            end else begin
              nbit <= nbit + 8'd1;
            end
          end
          ST_DATA: begin
            if (srise && !wr_dir) begin
              miso <= osr[DW-1];
              osr <= osr << 1;
              miso_oe <= 1'b1;
            end
            if (sfall) begin
              wsr <= {wsr[DW-2:0], din};
              nbit <= nbit + 8'd1;
              if (last_bit) begin
                st <= ST_DONE;
                miso_oe <= 1'b0;
                reg_wr <= wr_dir;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_wr_rd_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  assert_oe_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_off |=> !miso_oe);
  assert_oe_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !wr_dir);
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && !cs_off && $past(st == ST_DATA)) |-> $stable(reg_addr));
  assert_no_late_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE && $past(st == ST_DONE)) |-> (!reg_wr && !reg_rd));
endmodule

// File: tb/sim_spi_reg_slave.sv
module sim_spi_reg_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, reg_wr, reg_rd;
  logic [4:0] reg_addr;
  logic [39:0] reg_wdata, reg_rdata;
  logic [39:0] mem [32];
  int tests = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [4:0] wr_a, rd_a;
  logic [39:0] wr_d;
  bit in_read = 0;

  always #2.5 clk = ~clk;

  spi_reg_slave u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rd(reg_rd));

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) if (rst_n) begin
    if (reg_wr) begin wr_cnt++; wr_a = reg_addr; wr_d = reg_wdata; mem[reg_addr] = reg_wdata; end
    if (reg_rd) begin rd_cnt++; rd_a = reg_addr; end
  end

  always @(negedge clk) if (rst_n && miso_oe && !in_read) begin
    fails++;
    $display("FAIL R7 miso_oe high outside read data window: act=1 exp=0");
  end

  function automatic int nb_of(input int a); return (a % 5) + 1; endfunction

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic r);
    mosi = b; sclk = 1'b1;
    repeat (8) @(negedge clk);
    r = miso;
    sclk = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic sbyte(input logic [7:0] v, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) sbit(v[i], r[i]);
  endtask

  task automatic frame(input logic [7:0] cmd, input logic [39:0] d, input int nsend,
                       output logic [39:0] rd);
    logic [7:0] r;
    rd = '0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    sbyte(cmd, r);
    in_read = !cmd[7];
    for (int k = nsend - 1; k >= 0; k--) begin
      sbyte(d[8*k +: 8], r);
      rd = {rd[31:0], r};
    end
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    in_read = 0;
  endtask

  function automatic logic [39:0] mask(input int n);
    return (40'd1 << (8*n)) - 40'd1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [39:0] rd;
    int w0, r0;
    for (int a = 0; a < 32; a++) mem[a] = 40'hA5_1234_5678 ^ (40'(a) * 40'h01_0203_0405);
    repeat (3) @(negedge clk);
    chk("R1 reset oe", {39'd0, miso_oe}, 40'd0);
    chk("R1 reset wr/rd", {38'd0, reg_wr, reg_rd}, 40'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3/R4/R5: 4-byte write to address 3
    w0 = wr_cnt;
    frame(8'h83, 40'h00_DEAD_BEEF, nb_of(3), rd);
    chk("R5 write count a3", 40'(wr_cnt - w0), 40'd1);
    chk("R2 write addr a3", {35'd0, wr_a}, 40'd3);
    chk("R4 write data a3", wr_d, 40'h00_DEAD_BEEF);

    // R3: 5-byte write to address 4
    frame(8'h84, 40'hC3_1122_3344, nb_of(4), rd);
    chk("R4 write data a4 40-bit", wr_d, 40'hC3_1122_3344);

    // R2: bits 6..5 ignored, 1-byte write to address 0
    frame(8'hE0, 40'h5A, nb_of(0), rd);
    chk("R2 write addr with bits 6..5 set", {35'd0, wr_a}, 40'd0);
    chk("R4 write data a0 1-byte", wr_d, 40'h5A);

    // R6: 3-byte read of address 2
    r0 = rd_cnt; w0 = wr_cnt;
    frame(8'h02, 40'd0, nb_of(2), rd);
    chk("R6 read strobe count", 40'(rd_cnt - r0), 40'd1);
    chk("R6 read strobe addr", {35'd0, rd_a}, 40'd2);
    chk("R6 read data a2", rd, mem[2] & mask(3));
    chk("R5 no write on read", 40'(wr_cnt - w0), 40'd0);

    // R6: 5-byte read of the previously written address 4
    frame(8'h04, 40'd0, nb_of(4), rd);
    chk("R6 read back a4", rd, 40'hC3_1122_3344);
    chk("R1 oe after cs rise", {39'd0, miso_oe}, 40'd0);

    // R8: abort a 4-byte write to address 8 after 2 bytes
    w0 = wr_cnt;
    frame(8'h88, 40'h0000_ABCD, 2, rd);
    chk("R8 aborted write not committed", 40'(wr_cnt - w0), 40'd0);
    frame(8'h08, 40'd0, nb_of(8), rd);
    chk("R8 register unchanged after abort", rd, mem[8] & mask(4));

    // R9: extra byte after a 1-byte write to address 5
    w0 = wr_cnt;
    frame(8'h85, 40'h77_6600, 3, rd);
    chk("R9 single commit despite extra bytes", 40'(wr_cnt - w0), 40'd1);
    chk("R9 first byte kept", wr_d, 40'h77);

    // R9: extra byte after a read of address 10 (1 byte) gives no second strobe
    r0 = rd_cnt;
    frame(8'h0A, 40'd0, 2, rd);
    chk("R9 single strobe", 40'(rd_cnt - r0), 40'd1);
    chk("R6 read a10 first byte", {32'd0, rd[15:8]}, mem[10] & mask(1));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule